// File: doc/BRIEF.md
# Programmable Address Interleaving Permuter

This block maps a physical address onto a multi-bank memory through a small table that software can reload. The address is cut into four fields. From the top down they are the stripe, the gallery, the clump and the byte field. The stripe value and the low bits of the clump value are added together. Their sum selects one entry of a lookup table. That entry holds a bank number, and the bank number takes the place of the stripe field in the translated address. The gallery, clump and byte bits pass through untouched.

Because the bank order comes from a table and not from fixed address bits, the bank sequence and the number of banks can be changed at run time. A table built for the access pattern spreads strided accesses across the banks and so reduces bank conflicts.

A write port lets the local processor load one table entry per cycle. Translation is a single registered stage. The stripe width is `STRIPE_W`, and the table has 2^(`STRIPE_W`+1) entries of `STRIPE_W` bits each. A parameter set with `CLUMP_W` smaller than `STRIPE_W` is rejected at elaboration.

Top module: `ilv_permuter`

## Requirements
- R1: When a translation is accepted, bits [ADDR_W-STRIPE_W-1:0] of rsp_addr_o equal the same bits of the request address. These bits are the gallery, clump and byte fields, with the byte field in the lowest BYTE_W bits and the clump field directly above it. Bits [ADDR_W-1 -: STRIPE_W] carry the bank number read from the table.
- R2: The table index is the (STRIPE_W+1)-bit sum, without wrap, of the stripe field and the low STRIPE_W bits of the clump field. Clump bits above STRIPE_W do not change the index.
- R3: After reset, table entry i holds i modulo 2^STRIPE_W.
- R4: A cycle with tbl_we_i high writes tbl_bank_i into entry tbl_idx_i. Every translation accepted in a later cycle sees the new value.
- R5: A translation that reads the entry being written in the same cycle returns the entry's previous contents.
- R6: rsp_valid_o is high in exactly those cycles that follow a cycle with req_valid_i high. The latency is one cycle.
- R7: While rst_ni is low, rsp_valid_o and rsp_addr_o are zero.
- R8: After a cycle with req_valid_i low, rsp_addr_o keeps its previous value, even when a table write happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request address is valid this cycle |
| req_addr_i | input | ADDR_W | Physical address to translate |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_idx_i | input | STRIPE_W+1 | Table entry to write |
| tbl_bank_i | input | STRIPE_W | Bank number to store |
| rsp_valid_o | output | 1 | Translated address is valid |
| rsp_addr_o | output | ADDR_W | Translated address |

## Verification
The hardest case to reach from the ports is a table write and a translation that land on the same entry in the same cycle. The translation must return the old contents, and the next translation must return the new ones. The bench reaches this case by choosing a stripe and clump pair whose sum equals the written index. It then repeats the same address in the following cycle. Strided sequences from many base addresses run against both the reset table and a reloaded table, and idle cycles that carry writes check that the held output does not change.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Default bank for a table entry after reset: plain rotation.
  function automatic int unsigned rot_bank(int unsigned idx, int unsigned w);
    return idx % (32'd1 << w);
  endfunction
endpackage

// File: rtl/ilv_field_split.sv
module ilv_field_split #(
  parameter int STRIPE_W = 2,
  parameter int GALLERY_W = 4,
  parameter int CLUMP_W = 3,
  parameter int BYTE_W = 2,
  localparam int ADDR_W = STRIPE_W + GALLERY_W + CLUMP_W + BYTE_W,
  localparam int REST_W = ADDR_W - STRIPE_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [REST_W-1:0] rest_o,
  output logic [STRIPE_W:0] idx_o
);
  logic [STRIPE_W-1:0] stripe;
  logic [STRIPE_W-1:0] clump_lo;

  assign stripe   = addr_i[ADDR_W-1 -: STRIPE_W];
  assign clump_lo = addr_i[BYTE_W +: STRIPE_W];
  assign rest_o   = addr_i[REST_W-1:0];
  // One extra bit: the sum never wraps.
  assign idx_o    = {1'b0, stripe} + {1'b0, clump_lo};
endmodule

// File: rtl/ilv_bank_table.sv
module ilv_bank_table #(
  parameter int STRIPE_W = 2,
  localparam int DEPTH = 2 ** (STRIPE_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [STRIPE_W:0]   wr_idx_i,
  input  logic [STRIPE_W-1:0] wr_bank_i,
  input  logic [STRIPE_W:0]   rd_idx_i,
  output logic [STRIPE_W-1:0] rd_bank_o
);
  import ilv_pkg::*;

  logic [STRIPE_W-1:0] tbl_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tbl_q[i] <= STRIPE_W'(rot_bank(i, STRIPE_W));
      else if (we_i && (wr_idx_i == (STRIPE_W+1)'(i))) tbl_q[i] <= wr_bank_i;
    end
  end

  // The read is combinational, so a write in the same cycle is seen only afterwards.
  assign rd_bank_o = tbl_q[rd_idx_i];
endmodule

// File: rtl/ilv_xlate_reg.sv
module ilv_xlate_reg #(
  parameter int STRIPE_W = 2,
  parameter int REST_W = 9,
  localparam int ADDR_W = STRIPE_W + REST_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [STRIPE_W-1:0] bank_i,
  input  logic [REST_W-1:0]   rest_i,
  output logic                valid_o,
  output logic [ADDR_W-1:0]   addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) addr_o <= {bank_i, rest_i};
    end
  end
endmodule

// File: rtl/ilv_permuter.sv
module ilv_permuter #(
  parameter int STRIPE_W = 2,
  parameter int GALLERY_W = 4,
  parameter int CLUMP_W = 3,
  parameter int BYTE_W = 2,
  localparam int ADDR_W = STRIPE_W + GALLERY_W + CLUMP_W + BYTE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic                tbl_we_i,
  input  logic [STRIPE_W:0]   tbl_idx_i,
  input  logic [STRIPE_W-1:0] tbl_bank_i,
  output logic                rsp_valid_o,
  output logic [ADDR_W-1:0]   rsp_addr_o
);
  localparam int REST_W = ADDR_W - STRIPE_W;

  if (CLUMP_W < STRIPE_W) begin : g_bad_cfg
    $error("ilv_permuter: CLUMP_W must be >= STRIPE_W");
  end

  logic [REST_W-1:0]   rest;
  logic [STRIPE_W:0]   rd_idx;
  logic [STRIPE_W-1:0] bank;

  ilv_field_split #(
    .STRIPE_W(STRIPE_W), .GALLERY_W(GALLERY_W), .CLUMP_W(CLUMP_W), .BYTE_W(BYTE_W)
  ) u_split (
    .addr_i(req_addr_i),
    .rest_o(rest),
    .idx_o (rd_idx)
  );

  ilv_bank_table #(.STRIPE_W(STRIPE_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (tbl_we_i),
    .wr_idx_i (tbl_idx_i),
    .wr_bank_i(tbl_bank_i),
    .rd_idx_i (rd_idx),
    .rd_bank_o(bank)
  );

  ilv_xlate_reg #(.STRIPE_W(STRIPE_W), .REST_W(REST_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(req_valid_i),
    .bank_i (bank),
    .rest_i (rest),
    .valid_o(rsp_valid_o),
    .addr_o (rsp_addr_o)
  );
endmodule

// File: rtl/ilv_permuter_chk.sv
module ilv_permuter_chk #(
  parameter int AW = 11,
  parameter int W = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [AW-1:0] req_addr_i,
  input logic          rsp_valid_o,
  input logic [AW-1:0] rsp_addr_o
);
  a_r6_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r6_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r1_low_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_addr_o[AW-W-1:0] == $past(req_addr_i[AW-W-1:0]));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(rsp_addr_o));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r7_reset_clear: assert (rsp_valid_o == 1'b0 && rsp_addr_o == '0);
    end
  end
endmodule

bind ilv_permuter ilv_permuter_chk #(.AW(ADDR_W), .W(STRIPE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_addr_i (req_addr_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_addr_o (rsp_addr_o)
);

// File: tb/tb_ilv_permuter.sv
module tb_ilv_permuter;
  localparam int CLK_P = 10;
  localparam int W  = 2;
  localparam int GW = 4;
  localparam int CW = 3;
  localparam int BW = 2;
  localparam int AW = W + GW + CW + BW;
  localparam int TBL_N = 2 ** (W + 1);

  typedef struct {
    bit          v;
    logic [AW-1:0] a;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic          tbl_we_i = 1'b0;
  logic [W:0]    tbl_idx_i = '0;
  logic [W-1:0]  tbl_bank_i = '0;
  logic          rsp_valid_o;
  logic [AW-1:0] rsp_addr_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  exp_t q[$];
  logic [W-1:0]  mdl [TBL_N];
  logic [AW-1:0] last_exp = '0;

  always #(CLK_P/2) clk = ~clk;

  ilv_permuter #(.STRIPE_W(W), .GALLERY_W(GW), .CLUMP_W(CW), .BYTE_W(BW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .tbl_we_i(tbl_we_i), .tbl_idx_i(tbl_idx_i), .tbl_bank_i(tbl_bank_i),
    .rsp_valid_o(rsp_valid_o), .rsp_addr_o(rsp_addr_o)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic drive(input bit v, input logic [AW-1:0] a, input bit we,
                       input logic [W:0] ix, input logic [W-1:0] bk, input string tag);
    exp_t e;
    logic [W-1:0] s, c;
    logic [W:0] sum;
    @(negedge clk);
    req_valid_i = v; req_addr_i = a;
    tbl_we_i = we; tbl_idx_i = ix; tbl_bank_i = bk;
    if (v) begin
      s = a[AW-1 -: W];
      c = a[BW +: W];
      sum = {1'b0, s} + {1'b0, c};
      last_exp = {mdl[sum], a[AW-W-1:0]};  // old contents: read before write
    end
    e.v = v; e.a = last_exp; e.tag = tag;
    q.push_back(e);
    if (we) mdl[ix] = bk;
  endtask

  // Monitor: compares one queued item per cycle.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (rsp_valid_o !== e.v || rsp_addr_o !== e.a) begin
          fails++;
          $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
                   e.tag, rsp_valid_o, rsp_addr_o, e.v, e.a);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    int strides[5] = '{4, 12, 32, 20, 128};
    logic [AW-1:0] a;
    for (int i = 0; i < TBL_N; i++) mdl[i] = W'(i % (2 ** W));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: outputs zero during reset
    checks++;
    if (rsp_valid_o !== 1'b0 || rsp_addr_o !== '0) begin
      fails++;
      $display("FAIL R7: valid=%0b addr=%h expected valid=0 addr=0", rsp_valid_o, rsp_addr_o);
    end
    rst_ni = 1'b1;

    // R3 / R2: reset table, every stripe and clump value (upper clump bit included)
    for (int s = 0; s < 2 ** W; s++)
      for (int c = 0; c < 2 ** CW; c++) begin
        a = {W'(s), GW'(s * 5 + c), CW'(c), BW'(c + 1)};
        drive(1'b1, a, 1'b0, '0, '0, (c >= 2 ** W) ? "R2" : "R3");
      end

    // R4: reload with a non-rotating order while idle (R8 hold), then translate
    for (int i = 0; i < TBL_N; i++)
      drive(1'b0, '0, 1'b1, (W+1)'(i), W'((3 * i + 1) % (2 ** W)), "R8");

    // R1 / R4: strided sequences from many bases
    for (int b = 0; b < 40; b++)
      for (int si = 0; si < 5; si++)
        for (int k = 0; k < 8; k++) begin
          a = AW'(b * 37 + k * strides[si]);
          drive(1'b1, a, 1'b0, '0, '0, (si == 0) ? "R1" : "R4");
        end

    // R5: write entry 5 while a translation reads it (stripe 2 + clump 3)
    a = {W'(2), GW'(9), CW'(3), BW'(2)};
    drive(1'b1, a, 1'b1, (W+1)'(5), ~mdl[5], "R5");
    drive(1'b1, a, 1'b0, '0, '0, "R4");

    // R6: valid pattern with gaps and writes during gaps
    for (int k = 0; k < 12; k++) begin
      a = AW'(k * 133 + 7);
      drive(k % 3 != 0, a, k % 3 == 0, (W+1)'(k), W'(k), "R6");
    end
    drive(1'b0, '0, 1'b0, '0, '0, "R8");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule